// File: doc/BRIEF.md
# Dual-Port Write-Assist Enable Controller

This block decides, cycle by cycle, when the write-assist pull-down of each port of a dual-port memory array may be switched on. Each port presents a word-line active flag, an operation type (write or read) and a row address. The block records each port's operation and row on the clock edge at which that port's word-line is first seen high. When the second word-line rises while the first is still high, it classifies the pair.

A port's assist enable rises only when that port's write word-line rose first and a read on the other port then opens the same row while the write is still active. In that case the read would otherwise pull the storage node back through its bit-lines. If the read word-line rose first, or both rose on the same edge, raising assist would push the read data onto the writing port's bit-lines, so the enable stays low and the pair is reported as blocked. Both ports writing the same row raises no assist and is reported separately.

The enables and the 2-bit collision kind are registered. They follow the clock edge at which the second word-line is sampled high, and they clear after the first edge that samples either word-line low.

Top module: `dpwa_assist_ctrl`

## Requirements
- R1: While reset is active and after its release with both word-lines low, both assist enables are 0 and the collision kind is 2'b00.
- R2: If port X's word-line rises with a write and, on a later edge while X is still high, the other port's word-line rises with a read of the same row, X's enable is 1 and the collision kind is 2'b01 from the cycle after that edge. The reading port's enable stays 0. This holds for X = A and X = B.
- R3: If the two captured rows differ, neither enable rises and the collision kind stays 2'b00, whatever the operations and the order.
- R4: If the read word-line rises on an earlier edge than the write word-line of the same row, neither enable rises and the collision kind is 2'b10 while both are high.
- R5: If a write and a read of the same row rise on the same clock edge, neither enable rises and the collision kind is 2'b10.
- R6: If both ports write the same row with overlapping word-lines, in either order or together, neither enable rises and the collision kind is 2'b11.
- R7: After the first clock edge that samples either word-line low, both enables are 0 and the collision kind is 2'b00.
- R8: Operation type and row inputs are used only at the rising edge of the owning port's word-line. Changing them while that word-line stays high does not change the enables or the collision kind.
- R9: Two reads of the same row give collision kind 2'b00 and no enable.
- R10: A same-row write and read whose word-line pulses do not overlap at any clock edge never raise an enable, and the collision kind stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_wl | input | 1 | Port A word-line active |
| pa_wr | input | 1 | Port A operation, 1 = write, 0 = read |
| pa_row | input | ROW_W | Port A row address |
| pb_wl | input | 1 | Port B word-line active |
| pb_wr | input | 1 | Port B operation, 1 = write, 0 = read |
| pb_row | input | ROW_W | Port B row address |
| pa_assist | output | 1 | Port A write-assist enable |
| pb_assist | output | 1 | Port B write-assist enable |
| coll_kind | output | 2 | 00 none, 01 assisted write-then-read, 10 blocked read-then-write or simultaneous, 11 same-row write-write |

## Verification
The bench builds the block with ROW_W = 2. That makes every pair of row addresses, equal and unequal, small enough to sweep completely. The sweep crosses all row pairs with the four write/read combinations and with rise offsets from -5 to +5 cycles. This covers leading and trailing order, same-edge rises and pulses that never meet. Row and operation inputs are scrambled on every cycle except the rising one, so each overlap also checks that late input changes are ignored.

// File: rtl/dpwa_pkg.sv
`timescale 1ns/1ps
package dpwa_pkg;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'b00,
      CLS_ASSIST = 2'b01,
      CLS_BLOCK  = 2'b10,
      CLS_DUALWR = 2'b11
   } cls_e;

   // Classify a same-row pair by who opened first and what each does.
   function automatic cls_e pair_cls(input logic lead_wr,
                                     input logic late_wr,
                                     input logic simult);
      cls_e c;
      if (lead_wr && late_wr)        c = CLS_DUALWR;
      else if (!lead_wr && !late_wr) c = CLS_NONE;
      else if (simult)               c = CLS_BLOCK;
      else if (lead_wr)              c = CLS_ASSIST;
      else                           c = CLS_BLOCK;
      return c;
   endfunction

endpackage

// File: rtl/dpwa_port_track.sv
`timescale 1ns/1ps
module dpwa_port_track #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wl,
   input  logic             wr,
   input  logic [ROW_W-1:0] row,
   output logic             rise,
   output logic             cap_wr,
   output logic [ROW_W-1:0] cap_row
);
   logic wl_q;

   assign rise = wl & ~wl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wl_q    <= 1'b0;
         cap_wr  <= 1'b0;
         cap_row <= '0;
      end else begin
         wl_q <= wl;
         if (rise) begin
            cap_wr  <= wr;
            cap_row <= row;
         end
      end
   end
endmodule

// File: rtl/dpwa_classify.sv
`timescale 1ns/1ps
module dpwa_classify
   import dpwa_pkg::*;
#(
   parameter int ROW_W = 8
) (
   input  logic             wl_a,
   input  logic             rise_a,
   input  logic             wr_a,
   input  logic [ROW_W-1:0] row_a,
   input  logic             cap_wr_a,
   input  logic [ROW_W-1:0] cap_row_a,
   input  logic             wl_b,
   input  logic             rise_b,
   input  logic             wr_b,
   input  logic [ROW_W-1:0] row_b,
   input  logic             cap_wr_b,
   input  logic [ROW_W-1:0] cap_row_b,
   output logic             evt,
   output cls_e             cls,
   output logic             en_a,
   output logic             en_b
);
   always_comb begin
      evt  = 1'b0;
      cls  = CLS_NONE;
      en_a = 1'b0;
      en_b = 1'b0;
      if (rise_a && rise_b) begin
         evt = 1'b1;
         if (row_a == row_b) cls = pair_cls(wr_a, wr_b, 1'b1);
      end else if (rise_a && wl_b) begin
         evt = 1'b1;
         if (row_a == cap_row_b) begin
            cls  = pair_cls(cap_wr_b, wr_a, 1'b0);
            en_b = (cls == CLS_ASSIST);
         end
      end else if (rise_b && wl_a) begin
         evt = 1'b1;
         if (row_b == cap_row_a) begin
            cls  = pair_cls(cap_wr_a, wr_b, 1'b0);
            en_a = (cls == CLS_ASSIST);
         end
      end
   end
endmodule

// File: rtl/dpwa_strobe_reg.sv
`timescale 1ns/1ps
module dpwa_strobe_reg
   import dpwa_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic overlap,
   input  logic evt,
   input  cls_e cls_in,
   input  logic en_a_in,
   input  logic en_b_in,
   output cls_e cls_q,
   output logic en_a_q,
   output logic en_b_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || !overlap) begin
         cls_q  <= CLS_NONE;
         en_a_q <= 1'b0;
         en_b_q <= 1'b0;
      end else if (evt) begin
         cls_q  <= cls_in;
         en_a_q <= en_a_in;
         en_b_q <= en_b_in;
      end
   end
endmodule

// File: rtl/dpwa_assist_ctrl.sv
`timescale 1ns/1ps
module dpwa_assist_ctrl
   import dpwa_pkg::*;
#(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pa_wl,
   input  logic             pa_wr,
   input  logic [ROW_W-1:0] pa_row,
   input  logic             pb_wl,
   input  logic             pb_wr,
   input  logic [ROW_W-1:0] pb_row,
   output logic             pa_assist,
   output logic             pb_assist,
   output logic [1:0]       coll_kind
);
   localparam int NPORT = 2;

   if (ROW_W < 1 || ROW_W > 32) begin : g_bad_row_w
      $error("dpwa_assist_ctrl: ROW_W must lie in 1..32");
   end

   logic             wl_v   [NPORT];
   logic             wr_v   [NPORT];
   logic [ROW_W-1:0] row_v  [NPORT];
   logic             rise_v [NPORT];
   logic             cwr_v  [NPORT];
   logic [ROW_W-1:0] crow_v [NPORT];

   assign wl_v[0]  = pa_wl;
   assign wl_v[1]  = pb_wl;
   assign wr_v[0]  = pa_wr;
   assign wr_v[1]  = pb_wr;
   assign row_v[0] = pa_row;
   assign row_v[1] = pb_row;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dpwa_port_track #(.ROW_W(ROW_W)) u_trk (
         .clk     (clk),
         .rst_n   (rst_n),
         .wl      (wl_v[p]),
         .wr      (wr_v[p]),
         .row     (row_v[p]),
         .rise    (rise_v[p]),
         .cap_wr  (cwr_v[p]),
         .cap_row (crow_v[p])
      );
   end

   logic evt, en_a_n, en_b_n;
   cls_e cls_n, cls_q;

   dpwa_classify #(.ROW_W(ROW_W)) u_cls (
      .wl_a      (wl_v[0]),
      .rise_a    (rise_v[0]),
      .wr_a      (wr_v[0]),
      .row_a     (row_v[0]),
      .cap_wr_a  (cwr_v[0]),
      .cap_row_a (crow_v[0]),
      .wl_b      (wl_v[1]),
      .rise_b    (rise_v[1]),
      .wr_b      (wr_v[1]),
      .row_b     (row_v[1]),
      .cap_wr_b  (cwr_v[1]),
      .cap_row_b (crow_v[1]),
      .evt       (evt),
      .cls       (cls_n),
      .en_a      (en_a_n),
      .en_b      (en_b_n)
   );

   dpwa_strobe_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .overlap (pa_wl & pb_wl),
      .evt     (evt),
      .cls_in  (cls_n),
      .en_a_in (en_a_n),
      .en_b_in (en_b_n),
      .cls_q   (cls_q),
      .en_a_q  (pa_assist),
      .en_b_q  (pb_assist)
   );

   assign coll_kind = cls_q;
endmodule

// File: rtl/dpwa_assist_chk.sv
`timescale 1ns/1ps
module dpwa_assist_chk #(
   parameter int ROW_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pa_wl,
   input logic             pa_wr,
   input logic [ROW_W-1:0] pa_row,
   input logic             pb_wl,
   input logic             pb_wr,
   input logic [ROW_W-1:0] pb_row,
   input logic             pa_assist,
   input logic             pb_assist,
   input logic [1:0]       coll_kind
);
   assert_assist_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_assist && pb_assist));

   assert_assist_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_assist || pb_assist) |-> coll_kind == 2'b01);

   assert_assist_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pa_assist) |-> ($past(pb_wl) && !$past(pb_wl, 2) && $past(pa_wl, 2)));

   assert_block_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_kind == 2'b10 || coll_kind == 2'b11) |-> (!pa_assist && !pb_assist));

   assert_overlap_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_wl && pb_wl) |=> (!pa_assist && !pb_assist && coll_kind == 2'b00));

   assert_kind_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_wl && pb_wl && $past(pa_wl && pb_wl)) |=> $stable(coll_kind));
endmodule

bind dpwa_assist_ctrl dpwa_assist_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_dpwa_assist_ctrl.sv
`timescale 1ns/1ps
module sim_dpwa_assist_ctrl;
   localparam int RW  = 2;
   localparam int NR  = 1 << RW;
   localparam int SA  = 6;
   localparam int LA  = 4;
   localparam int LB  = 3;
   localparam int TN  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pa_wl = 0, pa_wr = 0, pb_wl = 0, pb_wr = 0;
   logic [RW-1:0] pa_row = '0, pb_row = '0;
   logic pa_assist, pb_assist;
   logic [1:0] coll_kind;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dpwa_assist_ctrl #(.ROW_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .pa_wl(pa_wl), .pa_wr(pa_wr), .pa_row(pa_row),
      .pb_wl(pb_wl), .pb_wr(pb_wr), .pb_row(pb_row),
      .pa_assist(pa_assist), .pb_assist(pb_assist), .coll_kind(coll_kind)
   );

   task automatic check(input string tag, input logic ea, input logic eb,
                        input logic [1:0] ek);
      total++;
      if (pa_assist !== ea || pb_assist !== eb || coll_kind !== ek) begin
         bad++;
         $display("FAIL %s: got a=%0b b=%0b kind=%0b, expected a=%0b b=%0b kind=%0b",
                  tag, pa_assist, pb_assist, coll_kind, ea, eb, ek);
      end
   endtask

   // One scenario: A high over [SA, SA+LA), B high over [SA+skew, SA+skew+LB).
   task automatic run_scn(input int ra, input int rb, input bit wa, input bit wb,
                          input int skew);
      int sb;
      bit ov, same;
      logic [1:0] cls;
      bit lead_a;
      string tag;
      sb     = SA + skew;
      ov     = (sb < SA + LA) && (SA < sb + LB);
      same   = (ra == rb);
      lead_a = (skew > 0);
      if (!ov || !same)       cls = 2'b00;
      else if (wa && wb)      cls = 2'b11;
      else if (!wa && !wb)    cls = 2'b00;
      else if (skew == 0)     cls = 2'b10;
      else if (lead_a ? wa : wb) cls = 2'b01;
      else                    cls = 2'b10;
      if (!same)                       tag = "R3";
      else if (!ov)                    tag = "R10";
      else if (wa && wb)               tag = "R6";
      else if (!wa && !wb)             tag = "R9";
      else if (skew == 0)              tag = "R5";
      else if (cls == 2'b01)           tag = "R2,R8";
      else                             tag = "R4";
      for (int t = 0; t < TN; t++) begin
         bit ha, hb, both, pboth;
         ha = (t >= SA) && (t < SA + LA);
         hb = (t >= sb) && (t < sb + LB);
         both  = ha && hb;
         pboth = (t > 0) && ((t-1) >= SA) && ((t-1) < SA + LA)
                 && ((t-1) >= sb) && ((t-1) < sb + LB);
         @(negedge clk);
         pa_wl  = ha;
         pb_wl  = hb;
         // inputs carry the intended values only on the rising cycle (R8)
         pa_row = (t == SA) ? RW'(ra) : RW'(ra ^ 1);
         pb_row = (t == sb) ? RW'(rb) : RW'(rb ^ 2);
         pa_wr  = (t == SA) ? wa : ~wa;
         pb_wr  = (t == sb) ? wb : ~wb;
         @(posedge clk);
         #5;
         if (both)
            check(tag, (cls == 2'b01) && lead_a, (cls == 2'b01) && !lead_a, cls);
         else if (pboth)
            check("R7", 1'b0, 1'b0, 2'b00);
         else
            check(tag, 1'b0, 1'b0, 2'b00);
      end
   endtask

   initial begin
      repeat (3) begin
         @(posedge clk);
         #5;
         check("R1", 1'b0, 1'b0, 2'b00);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check("R1", 1'b0, 1'b0, 2'b00);
      for (int ra = 0; ra < NR; ra++)
         for (int rb = 0; rb < NR; rb++)
            for (int op = 0; op < 4; op++)
               for (int sk = -5; sk <= 5; sk++)
                  run_scn(ra, rb, op[1], op[0], sk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule